// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock waveform that an I2C controller drives onto SCL. A prescaler counts functional-clock cycles and emits one tick every `div + 1` cycles. A phase controller then holds the clock low for `low + 2` ticks and released for `high + 2` ticks. With equal low and high fields, the bit rate is the functional clock divided by `(div + 1) * (field + 2) * 2`.

A byte sequencer uses two inputs to control it. `gen_enable` powers the generator. `bit_run` asks for another bit period. Alongside the clock drive request, the block gives the sequencer two single-cycle strobes. One marks the moment SDA may change, at the start of each low phase. The other marks the moment SDA should be sampled, at the middle of each high phase. The configuration inputs are captured only when a low phase begins, so a change made mid-bit can never shorten or stretch a half-period.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and until the first bit starts after reset, `scl_pull_low` is 0 and both strobes are 0.
- R2: A low phase lasts exactly `(cfg_low + 2) * (cfg_div + 1)` clock cycles, where `cfg_low` is in 0..7 and `cfg_div` is in 0..65535.
- R3: A high phase between two bits lasts exactly `(cfg_high + 2) * (cfg_div + 1)` clock cycles.
- R4: `sda_change_stb` is 1 for exactly one cycle, in the first cycle of every low phase, and is 0 at all other times.
- R5: `sda_sample_stb` is 1 for exactly one cycle per high phase. Counting the first released cycle as offset 0, it occurs at offset `floor((cfg_high + 2) / 2) * (cfg_div + 1)`.
- R6: When `gen_enable` and `bit_run` are both 1 at a rising edge while the generator is idle, `scl_pull_low` rises right after that edge together with `sda_change_stb`, and the first low phase has full length.
- R7: `bit_run` is looked at only when a high phase ends. If it is 0 then, the bit that is under way completes with both phases and the generator returns to idle with SCL released.
- R8: When `gen_enable` is 0 at a rising edge, the generator goes idle right after that edge (SCL released, no strobes) and its prescaler clears. The next bit then starts with a full-length low phase.
- R9: Values on `cfg_div`, `cfg_low` and `cfg_high` take effect only at the start of the next low phase. The bit under way keeps its phase lengths.
- R10: While idle, with `gen_enable` at 1 and `bit_run` at 0, no strobe is produced and SCL stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_enable | input | 1 | Generator enable; 0 forces idle and clears the prescaler |
| bit_run | input | 1 | Request for another bit period, sampled at high-phase end or while idle |
| cfg_div | input | 16 | Prescaler value; one tick every cfg_div+1 cycles |
| cfg_low | input | 3 | Low phase length minus 2, in ticks |
| cfg_high | input | 3 | High phase length minus 2, in ticks |
| scl_pull_low | output | 1 | 1 requests the SCL pad to be driven low; 0 releases it |
| sda_change_stb | output | 1 | One-cycle pulse at the start of each low phase |
| sda_sample_stb | output | 1 | One-cycle pulse at the midpoint of each high phase |

## Verification
Several rules are checked by the assertions on every cycle. The change strobe appears only while SCL is pulled low, the sample strobe appears only while SCL is released, and the two never coincide. A disable empties the controller and the prescaler on the next edge. The prescaler count stays within the latched divider, and the latched configuration stays unchanged except when a low phase begins. What only the bench's scenarios can show is exact lengths in cycles: each phase over a spread of divider and field values, the position of the sample pulse, and the start latency. The same holds for a run request dropped mid-bit, a disable in mid-phase followed by a restart, and a configuration rewrite that must wait for the next bit.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } sclg_phase_e;

endpackage

// File: rtl/sclg_prescaler.sv
module sclg_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == div_i);
  assign tick_o = count_en & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!count_en) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R8: the prescaler is cleared by the cycle after counting stops
  assert_prescale_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> (cnt_q == '0));

  // R2: the count never passes the divider value it is comparing against
  assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> (cnt_q <= div_i));

endmodule

// File: rtl/sclg_phase_ctrl.sv
module sclg_phase_ctrl
  import sclg_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int FLD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [FLD_W-1:0] cfg_low_i,
  input  logic [FLD_W-1:0] cfg_high_i,
  output sclg_phase_e      phase_o,
  output logic [DIV_W-1:0] div_o,
  output logic             enter_low_o,
  output logic             mid_hit_o
);

  localparam int CNT_W = FLD_W + 1;

  sclg_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [FLD_W-1:0] low_q, low_d;
  logic [FLD_W-1:0] high_q, high_d;
  logic [CNT_W-1:0] low_last;
  logic [CNT_W-1:0] high_last;
  logic [CNT_W-1:0] mid_idx;
  logic             cfg_load;

  // a field f stands for f+2 ticks, so the last tick index is f+1
  assign low_last  = {1'b0, low_q} + 1'b1;
  assign high_last = {1'b0, high_q} + 1'b1;
  // floor((f+2)/2) - 1 reduces to f >> 1
  assign mid_idx   = {1'b0, high_q} >> 1;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    cfg_load = 1'b0;
    mid_hit_o = 1'b0;
    if (!enable_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (run_i) begin
            phase_d  = PH_LOW;
            cnt_d    = '0;
            cfg_load = 1'b1;
          end
        end
        PH_LOW: begin
          if (tick_i) begin
            if (cnt_q == low_last) begin
              phase_d = PH_HIGH;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (tick_i) begin
            if (cnt_q == mid_idx) begin
              mid_hit_o = 1'b1;
            end
            if (cnt_q == high_last) begin
              cnt_d = '0;
              if (run_i) begin
                phase_d  = PH_LOW;
                cfg_load = 1'b1;
              end else begin
                phase_d = PH_IDLE;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_comb begin
    div_d  = div_q;
    low_d  = low_q;
    high_d = high_q;
    if (cfg_load) begin
      div_d  = cfg_div_i;
      low_d  = cfg_low_i;
      high_d = cfg_high_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (cfg_load) begin
      div_q  <= div_d;
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  assign phase_o     = phase_q;
  assign div_o       = div_q;
  assign enter_low_o = cfg_load;

  // R8: disable empties the controller by the next edge
  assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (phase_q == PH_IDLE));

  // R9: the captured configuration only moves when a low phase begins
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(div_q) && $stable(low_q) && $stable(high_q)));

  // R2: tick index stays inside the low phase length
  assert_low_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q <= low_last));

  // R3: tick index stays inside the high phase length
  assert_high_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) |-> (cnt_q <= high_last));

endmodule

// File: rtl/sclg_strobe_gen.sv
module sclg_strobe_gen
  import sclg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enter_low_i,
  input  logic        mid_hit_i,
  input  sclg_phase_e phase_i,
  output logic        change_o,
  output logic        sample_o
);

  logic change_q, change_d;
  logic sample_q, sample_d;

  always_comb begin
    change_d = enter_low_i;
    sample_d = mid_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      change_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      change_q <= change_d;
      sample_q <= sample_d;
    end
  end

  assign change_o = change_q;
  assign sample_o = sample_q;

  // R4: change strobe only while SCL is pulled low
  assert_change_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    change_q |-> (phase_i == PH_LOW));

  // R5: sample strobe only while SCL is released in a bit
  assert_sample_in_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_q |-> (phase_i == PH_HIGH));

  // R10: idle emits no strobe, and the two never overlap
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_IDLE) |-> !(change_q || sample_q));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({change_q, sample_q}));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclg_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int FLD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_enable,
  input  logic             bit_run,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FLD_W-1:0] cfg_low,
  input  logic [FLD_W-1:0] cfg_high,
  output logic             scl_pull_low,
  output logic             sda_change_stb,
  output logic             sda_sample_stb
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  sclg_phase_e            phase;
  logic [DIV_W-1:0]       div_lat;
  logic                   tick;
  logic                   pre_en;
  logic                   enter_low;
  logic                   mid_hit;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  assign pre_en = gen_enable && (phase != PH_IDLE);

  sclg_prescaler #(
    .DIV_W (DIV_W)
  ) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .count_en (pre_en),
    .div_i    (div_lat),
    .tick_o   (tick)
  );

  sclg_phase_ctrl #(
    .DIV_W (DIV_W),
    .FLD_W (FLD_W)
  ) u_phase (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .enable_i    (gen_enable),
    .run_i       (bit_run),
    .tick_i      (tick),
    .cfg_div_i   (cfg_div),
    .cfg_low_i   (cfg_low),
    .cfg_high_i  (cfg_high),
    .phase_o     (phase),
    .div_o       (div_lat),
    .enter_low_o (enter_low),
    .mid_hit_o   (mid_hit)
  );

  sclg_strobe_gen u_strobe (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .enter_low_i (enter_low),
    .mid_hit_i   (mid_hit),
    .phase_i     (phase),
    .change_o    (sda_change_stb),
    .sample_o    (sda_sample_stb)
  );

  assign scl_pull_low = (phase == PH_LOW);

  // R1: reset leaves the clock released and quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_int |-> !(scl_pull_low || sda_change_stb || sda_sample_stb));

  // R6: a low phase can only begin with the change strobe
  assert_low_start_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(scl_pull_low) |-> sda_change_stb);

endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

  logic        clk;
  logic        rst_n;
  logic        gen_enable;
  logic        bit_run;
  logic [15:0] cfg_div;
  logic [2:0]  cfg_low;
  logic [2:0]  cfg_high;
  logic        scl_pull_low;
  logic        sda_change_stb;
  logic        sda_sample_stb;

  int n_tests;
  int n_fail;

  scl_timing_gen dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .gen_enable     (gen_enable),
    .bit_run        (bit_run),
    .cfg_div        (cfg_div),
    .cfg_low        (cfg_low),
    .cfg_high       (cfg_high),
    .scl_pull_low   (scl_pull_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam int NVEC = 8;
  localparam int VDIV  [NVEC] = '{0, 0, 1, 2, 3, 4, 0, 300};
  localparam int VLOW  [NVEC] = '{0, 7, 3, 0, 6, 2, 5, 0};
  localparam int VHIGH [NVEC] = '{0, 7, 5, 7, 1, 2, 0, 0};

  // waveform monitor, sampled on the falling edge
  int lowstarts, last_low, last_high, smp_off, smp_count, chg_bad;
  int low_cnt, hi_cnt;
  bit prev_scl;

  always @(negedge clk) begin
    if (!rst_n) begin
      lowstarts = 0; last_low = 0; last_high = 0; smp_off = -1;
      smp_count = 0; chg_bad = 0; low_cnt = 0; hi_cnt = 0; prev_scl = 0;
    end else begin
      if (scl_pull_low && !prev_scl) begin
        lowstarts++;
        if (hi_cnt > 0) last_high = hi_cnt;
        low_cnt = 1;
        if (!sda_change_stb) chg_bad++;
      end else if (scl_pull_low) begin
        low_cnt++;
        if (sda_change_stb) chg_bad++;
      end else if (prev_scl) begin
        last_low = low_cnt;
        hi_cnt = 1;
      end else begin
        hi_cnt++;
      end
      if (!scl_pull_low && sda_change_stb) chg_bad++;
      if (sda_sample_stb) begin
        smp_count++;
        smp_off = hi_cnt - 1;
      end
      prev_scl = scl_pull_low;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wait_starts(input int n);
    int target;
    target = lowstarts + n;
    for (int i = 0; i < 20000; i++) begin
      if (lowstarts >= target) break;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic set_cfg(input int d, input int l, input int h);
    cfg_div  = d[15:0];
    cfg_low  = l[2:0];
    cfg_high = h[2:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base_s, base_smp, base_chg;
    n_tests = 0;
    n_fail  = 0;
    rst_n = 1'b0;
    gen_enable = 1'b0;
    bit_run = 1'b0;
    set_cfg(0, 0, 0);
    step(3);
    // R1: during reset
    chk("R1 scl", scl_pull_low, 0);
    chk("R1 strobes", sda_change_stb | sda_sample_stb, 0);
    rst_n = 1'b1;
    step(5);
    chk("R1 scl after release", scl_pull_low, 0);

    // R10: enabled but not running
    gen_enable = 1'b1;
    base_smp = smp_count;
    base_chg = chg_bad;
    step(50);
    chk("R10 no sample", smp_count - base_smp, 0);
    chk("R10 no low start", lowstarts, 0);
    chk("R10 scl released", scl_pull_low, 0);

    // vector walk: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      int ed, el, eh;
      gen_enable = 1'b0;
      set_cfg(VDIV[v], VLOW[v], VHIGH[v]);
      step(3);
      ed = VDIV[v] + 1;
      el = (VLOW[v] + 2) * ed;
      eh = (VHIGH[v] + 2) * ed;
      base_chg = chg_bad;
      gen_enable = 1'b1;
      bit_run = 1'b1;
      wait_starts(2);
      chk($sformatf("R2 low len v%0d", v), last_low, el);
      chk($sformatf("R3 high len v%0d", v), last_high, eh);
      chk($sformatf("R5 sample offset v%0d", v), smp_off, ((VHIGH[v] + 2) / 2) * ed);
      chk($sformatf("R4 change placement v%0d", v), chg_bad - base_chg, 0);
      bit_run = 1'b0;
      step(2 * (el + eh) + 5);
    end

    // R6: start latency
    gen_enable = 1'b0;
    set_cfg(1, 2, 2);
    step(3);
    gen_enable = 1'b1;
    bit_run = 1'b1;
    step(1);
    chk("R6 scl low after edge", scl_pull_low, 1);
    chk("R6 change with start", sda_change_stb, 1);
    wait_starts(1);
    chk("R6 first low full", last_low, 8);

    // R7: run dropped early in a bit
    gen_enable = 1'b0;
    bit_run = 1'b0;
    set_cfg(1, 1, 1);
    step(3);
    gen_enable = 1'b1;
    bit_run = 1'b1;
    wait_starts(1);
    base_s = lowstarts;
    base_smp = smp_count;
    step(1);
    bit_run = 1'b0;
    step(40);
    chk("R7 no further bit", lowstarts - base_s, 0);
    chk("R7 bit sampled once", smp_count - base_smp, 1);
    chk("R7 low completed", last_low, 6);
    chk("R7 released", scl_pull_low, 0);

    // R8: disable in mid low phase, then restart
    set_cfg(2, 3, 3);
    bit_run = 1'b1;
    wait_starts(1);
    step(5);
    gen_enable = 1'b0;
    step(1);
    chk("R8 released", scl_pull_low, 0);
    chk("R8 no strobe", sda_change_stb | sda_sample_stb, 0);
    step(4);
    gen_enable = 1'b1;
    wait_starts(2);
    chk("R8 full low after restart", last_low, 15);

    // R9: rewrite configuration at the start of a bit
    gen_enable = 1'b0;
    set_cfg(1, 0, 4);
    step(3);
    gen_enable = 1'b1;
    bit_run = 1'b1;
    wait_starts(1);
    set_cfg(0, 5, 1);
    wait_starts(1);
    chk("R9 old low kept", last_low, 4);
    chk("R9 old high kept", last_high, 12);
    wait_starts(1);
    chk("R9 new low", last_low, 7);
    chk("R9 new high", last_high, 3);
    bit_run = 1'b0;
    step(30);
    chk("R7 idle after last bit", scl_pull_low, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule